// File: doc/BRIEF.md
# I2C Command and Data Queue Front End

This block is the queueing layer that sits between a host register bus and the bus engine of an I2C master. The host writes 9-bit command words into a transmit queue. Bit 8 of a command word marks a read request, and the low byte carries the data for a write. The bus engine drains that queue through a valid/pop handshake. Bytes the engine receives are pushed into a receive queue, and the host pops them by reading the data register.

Fill levels and two programmable thresholds are readable and writable over the same register port. Two registered level flags are derived from them: one for a transmit queue that has drained to its threshold, and one for a receive queue that has climbed above its threshold. Single-cycle event strobes report an overflow of either queue and an underflow of the receive queue. An abort input flushes both queues, and so does clearing the enable bit.

Read requests use transmit-queue space and also reserve receive space. A read request is only accepted while the bytes already received, plus the reads still outstanding, leave room in the receive queue.

Top module: `i2cq_front`

## Requirements
- R1: After reset the enable bit is 0, both levels read 0, the transmit-low flag is 1, the receive-high flag is 0, and cmd_valid is 0.
- R2: While enabled, a host write to offset 0x10 queues wdata[8:0], where bit 8 = 1 marks a read request and bits 7:0 are the byte. cmd_valid is high while the queue holds an entry, and cmd_is_read/cmd_byte show the oldest entry. cmd_pop removes that entry.
- R3: A write to offset 0x10 while the transmit queue holds DEPTH entries is dropped, and tx_over is high for the one cycle after that write.
- R4: A read request is dropped with a tx_over strobe when the receive level plus the outstanding read requests equals DEPTH, even if the transmit queue has room.
- R5: A host read of offset 0x10 returns the oldest received byte in host_rdata[7:0] on the cycle after the read and removes it. Bytes come out in the order they were pushed.
- R6: A host read of offset 0x10 while the receive queue is empty returns 0, and rx_under is high for the one cycle after that read.
- R7: An rx_push while the receive queue holds DEPTH bytes is dropped, and rx_over is high for the one cycle after that push.
- R8: Reads return the transmit level at 0x74, the receive level at 0x78, the enable bit at 0x6c, the receive threshold at 0x38 and the transmit threshold at 0x3c. Writes to 0x6c, 0x38 and 0x3c set the enable bit (wdata[0]) and the thresholds.
- R9: tx_low is 1 when the transmit level is at or below the transmit threshold. rx_high is 1 when the receive level is above the receive threshold. Both flags are registered and lag the level by one cycle.
- R10: An abort pulse empties both queues and clears the outstanding read count by the following cycle.
- R11: While the enable bit is 0, both queues stay empty. Data writes and engine pushes are ignored without raising tx_over or rx_over.
- R12: A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data, valid the cycle after host_rd |
| cmd_valid | output | 1 | Transmit queue has an entry for the engine |
| cmd_is_read | output | 1 | Oldest entry is a read request |
| cmd_byte | output | 8 | Byte of the oldest entry |
| cmd_pop | input | 1 | Engine consumes the oldest entry |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| abort | input | 1 | Flush both queues |
| tx_low | output | 1 | Transmit level at or below its threshold |
| rx_high | output | 1 | Receive level above its threshold |
| tx_over | output | 1 | Transmit overflow strobe |
| rx_over | output | 1 | Receive overflow strobe |
| rx_under | output | 1 | Receive underflow strobe |

## Verification
The assertions check the following on every cycle:
- both levels stay within DEPTH;
- received bytes plus outstanding reads never exceed DEPTH;
- abort and a cleared enable leave both queues empty;
- cmd_valid is never raised on an empty queue;
- each strobe follows a matching host or engine access.

Only the bench scenarios can show the rest: byte ordering through both queues, the exact values returned by register reads, the reservation refusal while the transmit queue still has room, and flag changes at given thresholds.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam logic [7:0] OFS_DATA   = 8'h10;
  localparam logic [7:0] OFS_RX_THR = 8'h38;
  localparam logic [7:0] OFS_TX_THR = 8'h3C;
  localparam logic [7:0] OFS_ENABLE = 8'h6C;
  localparam logic [7:0] OFS_TX_LVL = 8'h74;
  localparam logic [7:0] OFS_RX_LVL = 8'h78;

  localparam int CMD_W    = 9;
  localparam int READ_BIT = 8;

  typedef struct packed {
    logic       rd;
    logic [7:0] payload;
  } cmd_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_level_flags.sv
module i2cq_level_flags #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] tx_thr,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_thr,
  output logic             tx_low,
  output logic             rx_high
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_low  <= 1'b1;
      rx_high <= 1'b0;
    end else begin
      tx_low  <= (tx_level <= tx_thr);
      rx_high <= (rx_level > rx_thr);
    end
  end
endmodule

// File: rtl/i2cq_front.sv
module i2cq_front #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              cmd_valid,
  output logic              cmd_is_read,
  output logic [7:0]        cmd_byte,
  input  logic              cmd_pop,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              abort,
  output logic              tx_low,
  output logic              rx_high,
  output logic              tx_over,
  output logic              rx_over,
  output logic              rx_under
);
  import i2cq_pkg::*;

  logic             en_q;
  logic [CNT_W-1:0] tx_thr_q, rx_thr_q, pend_q;
  logic [CNT_W-1:0] tx_level, rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             flush;
  cmd_t             tx_in, tx_head;
  logic [7:0]       rx_head;
  logic             wr_data, rd_data, is_rd_cmd, rx_room_ok;
  logic             tx_accept, tx_reject, rx_accept, rx_drop, rx_pop;
  logic             pend_inc, pend_dec;

  assign flush      = abort || !en_q;
  assign wr_data    = host_wr && (host_addr == ADDR_W'(OFS_DATA));
  assign rd_data    = host_rd && (host_addr == ADDR_W'(OFS_DATA));
  assign is_rd_cmd  = host_wdata[READ_BIT];
  assign rx_room_ok = ({1'b0, rx_level} + {1'b0, pend_q}) < (CNT_W + 1)'(DEPTH);

  assign tx_accept  = wr_data && !flush && !tx_full && (!is_rd_cmd || rx_room_ok);
  assign tx_reject  = wr_data && !flush && !tx_accept;
  assign rx_accept  = rx_push && !flush && !rx_full;
  assign rx_drop    = rx_push && !flush && rx_full;
  assign rx_pop     = rd_data && !rx_empty;
  assign pend_inc   = tx_accept && is_rd_cmd;
  assign pend_dec   = rx_accept && (pend_q != '0);

  assign tx_in.rd      = is_rd_cmd;
  assign tx_in.payload = host_wdata[7:0];

  i2cq_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (tx_accept),
    .din   (tx_in),
    .pop   (cmd_pop),
    .dout  (tx_head),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  i2cq_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (rx_accept),
    .din   (rx_byte),
    .pop   (rx_pop),
    .dout  (rx_head),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  i2cq_level_flags #(.CNT_W(CNT_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .tx_level (tx_level),
    .tx_thr   (tx_thr_q),
    .rx_level (rx_level),
    .rx_thr   (rx_thr_q),
    .tx_low   (tx_low),
    .rx_high  (rx_high)
  );

  assign cmd_valid   = en_q && !tx_empty;
  assign cmd_is_read = tx_head.rd;
  assign cmd_byte    = tx_head.payload;

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (host_wr) begin
      case (host_addr)
        ADDR_W'(OFS_ENABLE): en_q     <= host_wdata[0];
        ADDR_W'(OFS_TX_THR): tx_thr_q <= host_wdata[CNT_W-1:0];
        ADDR_W'(OFS_RX_THR): rx_thr_q <= host_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // outstanding read requests reserve receive space
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_q <= '0;
    end else begin
      case ({pend_inc, pend_dec})
        2'b10:   pend_q <= pend_q + CNT_W'(1);
        2'b01:   pend_q <= pend_q - CNT_W'(1);
        default: pend_q <= pend_q;
      endcase
    end
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        ADDR_W'(OFS_DATA):   host_rdata <= rx_empty ? '0 : DATA_W'(rx_head);
        ADDR_W'(OFS_TX_LVL): host_rdata <= DATA_W'(tx_level);
        ADDR_W'(OFS_RX_LVL): host_rdata <= DATA_W'(rx_level);
        ADDR_W'(OFS_ENABLE): host_rdata <= DATA_W'(en_q);
        ADDR_W'(OFS_TX_THR): host_rdata <= DATA_W'(tx_thr_q);
        ADDR_W'(OFS_RX_THR): host_rdata <= DATA_W'(rx_thr_q);
        default:             host_rdata <= '0;
      endcase
    end
  end

  // event strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_over  <= 1'b0;
      rx_over  <= 1'b0;
      rx_under <= 1'b0;
    end else begin
      tx_over  <= tx_reject;
      rx_over  <= rx_drop;
      rx_under <= rd_data && rx_empty;
    end
  end
endmodule

// File: rtl/i2cq_front_chk.sv
module i2cq_front_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic             abort,
  input logic [CNT_W-1:0] tx_level,
  input logic [CNT_W-1:0] rx_level,
  input logic [CNT_W-1:0] pend_q,
  input logic             cmd_valid,
  input logic             tx_over,
  input logic             rx_over,
  input logic             rx_under,
  input logic             host_wr,
  input logic             host_rd,
  input logic [7:0]       host_addr,
  input logic             rx_push
);
  a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= CNT_W'(DEPTH)) && (rx_level <= CNT_W'(DEPTH)));

  a_r4_reservation: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, rx_level} + {1'b0, pend_q}) <= (CNT_W + 1)'(DEPTH));

  a_r10_abort_flush: assert property (@(posedge clk) disable iff (rst)
    abort |=> (tx_level == '0) && (rx_level == '0) && (pend_q == '0));

  a_r11_disabled_empty: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (tx_level == '0) && (rx_level == '0));

  a_r2_valid_has_entry: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (tx_level != '0));

  a_r3_over_after_write: assert property (@(posedge clk) disable iff (rst)
    tx_over |-> $past(host_wr && host_addr == 8'h10));

  a_r7_over_after_push: assert property (@(posedge clk) disable iff (rst)
    rx_over |-> $past(rx_push && rx_level == CNT_W'(DEPTH)));

  a_r6_under_after_read: assert property (@(posedge clk) disable iff (rst)
    rx_under |-> $past(host_rd && host_addr == 8'h10 && rx_level == '0));
endmodule

bind i2cq_front i2cq_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .abort     (abort),
  .tx_level  (tx_level),
  .rx_level  (rx_level),
  .pend_q    (pend_q),
  .cmd_valid (cmd_valid),
  .tx_over   (tx_over),
  .rx_over   (rx_over),
  .rx_under  (rx_under),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .host_addr (host_addr),
  .rx_push   (rx_push)
);

// File: tb/test_i2cq_front.sv
`timescale 1ns/1ps
module test_i2cq_front;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cmd_valid, cmd_is_read;
  logic [7:0]  cmd_byte;
  logic        cmd_pop = 0, rx_push = 0, abort = 0;
  logic [7:0]  rx_byte = '0;
  logic        tx_low, rx_high, tx_over, rx_over, rx_under;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2cq_front #(.DEPTH(DEPTH)) i_i2cq_front (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read), .cmd_byte(cmd_byte),
    .cmd_pop(cmd_pop), .rx_push(rx_push), .rx_byte(rx_byte), .abort(abort),
    .tx_low(tx_low), .rx_high(rx_high), .tx_over(tx_over),
    .rx_over(rx_over), .rx_under(rx_under)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output logic ovf);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); ovf = tx_over; host_wr = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v, output logic und);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); v = host_rdata; und = rx_under; host_rd = 0;
  endtask

  task automatic eng_push(input logic [7:0] b, output logic ovf);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); ovf = rx_over; rx_push = 0;
  endtask

  task automatic eng_pop(output logic [8:0] w, output logic v);
    @(negedge clk); v = cmd_valid; w = {cmd_is_read, cmd_byte}; cmd_pop = 1;
    @(negedge clk); cmd_pop = 0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input int exp, input string req);
    logic [31:0] v; logic u;
    bus_rd(a, v, u);
    check(v == 32'(exp), req, int'(v), exp);
  endtask

  task automatic t_reset();
    check(tx_low == 1'b1, "R1 tx_low", int'(tx_low), 1);
    check(rx_high == 1'b0, "R1 rx_high", int'(rx_high), 0);
    check(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
    expect_reg(8'h6C, 0, "R1 enable");
    expect_reg(8'h74, 0, "R1 tx level");
    expect_reg(8'h78, 0, "R1 rx level");
  endtask

  task automatic t_disabled_ignore();
    logic o;
    bus_wr(8'h10, 32'h055, o);
    check(o == 1'b0, "R11 no tx_over when disabled", int'(o), 0);
    expect_reg(8'h74, 0, "R11 tx level disabled");
    eng_push(8'h33, o);
    check(o == 1'b0, "R11 no rx_over when disabled", int'(o), 0);
    expect_reg(8'h78, 0, "R11 rx level disabled");
  endtask

  task automatic t_order();
    logic o, v, u; logic [8:0] w; logic [31:0] d;
    bus_wr(8'h10, 32'h05A, o);
    bus_wr(8'h10, 32'h1FF, o);
    bus_wr(8'h10, 32'h0C3, o);
    expect_reg(8'h74, 3, "R8 tx level 3");
    eng_pop(w, v);
    check(v && w == 9'h05A, "R2 first cmd", int'(w), 'h05A);
    eng_pop(w, v);
    check(v && w == 9'h1FF, "R2 read cmd", int'(w), 'h1FF);
    eng_pop(w, v);
    check(v && w == 9'h0C3, "R2 third cmd", int'(w), 'h0C3);
    check(cmd_valid == 1'b0, "R2 valid drops", int'(cmd_valid), 0);
    eng_push(8'h77, o);
    expect_reg(8'h78, 1, "R8 rx level 1");
    bus_rd(8'h10, d, u);
    check(d == 32'h77 && !u, "R5 byte read", int'(d), 'h77);
  endtask

  task automatic t_tx_overflow();
    logic o;
    for (int i = 0; i < DEPTH; i++) begin
      bus_wr(8'h10, 32'(i), o);
      check(o == 1'b0, "R3 fill accepted", int'(o), 0);
    end
    bus_wr(8'h10, 32'h0AA, o);
    check(o == 1'b1, "R3 overflow strobe", int'(o), 1);
    expect_reg(8'h74, DEPTH, "R3 level stays full");
    pulse_abort();
    expect_reg(8'h74, 0, "R10 tx flushed");
    check(cmd_valid == 1'b0, "R10 no cmd after abort", int'(cmd_valid), 0);
  endtask

  task automatic t_reservation();
    logic o, v, u; logic [8:0] w; logic [31:0] d;
    for (int i = 0; i < 3; i++) eng_push(8'hA0 + 8'(i), o);
    for (int i = 0; i < 5; i++) begin
      bus_wr(8'h10, 32'h100, o);
      check(o == 1'b0, "R4 read accepted", int'(o), 0);
    end
    bus_wr(8'h10, 32'h100, o);
    check(o == 1'b1, "R4 read refused", int'(o), 1);
    expect_reg(8'h74, 5, "R4 tx level 5");
    for (int i = 0; i < 5; i++) begin
      eng_pop(w, v);
      check(v && w[8], "R2 read request bit", int'(w), 'h100);
    end
    for (int i = 0; i < 5; i++) eng_push(8'h10 + 8'(i), o);
    eng_push(8'hEE, o);
    check(o == 1'b1, "R7 rx overflow strobe", int'(o), 1);
    expect_reg(8'h78, DEPTH, "R7 rx level full");
    for (int i = 0; i < DEPTH; i++) begin
      int e;
      e = (i < 3) ? ('hA0 + i) : ('h10 + i - 3);
      bus_rd(8'h10, d, u);
      check(d == 32'(e), "R5 rx order", int'(d), e);
    end
    bus_rd(8'h10, d, u);
    check(d == 0, "R6 empty read zero", int'(d), 0);
    check(u == 1'b1, "R6 underflow strobe", int'(u), 1);
  endtask

  task automatic t_thresholds();
    logic o;
    bus_wr(8'h3C, 32'd2, o);
    bus_wr(8'h38, 32'd1, o);
    expect_reg(8'h3C, 2, "R8 tx threshold");
    expect_reg(8'h38, 1, "R8 rx threshold");
    check(tx_low == 1'b1, "R9 tx_low at 0", int'(tx_low), 1);
    for (int i = 0; i < 3; i++) bus_wr(8'h10, 32'h011, o);
    @(negedge clk);
    check(tx_low == 1'b0, "R9 tx_low above thr", int'(tx_low), 0);
    eng_push(8'h01, o);
    @(negedge clk);
    check(rx_high == 1'b0, "R9 rx_high at thr", int'(rx_high), 0);
    eng_push(8'h02, o);
    @(negedge clk);
    check(rx_high == 1'b1, "R9 rx_high above thr", int'(rx_high), 1);
    pulse_abort();
    expect_reg(8'h78, 0, "R10 rx flushed");
  endtask

  task automatic t_unmapped();
    expect_reg(8'h20, 0, "R12 unmapped");
  endtask

  task automatic t_disable_flush();
    logic o;
    bus_wr(8'h10, 32'h012, o);
    eng_push(8'h34, o);
    bus_wr(8'h6C, 32'd0, o);
    @(negedge clk);
    expect_reg(8'h74, 0, "R11 tx emptied");
    expect_reg(8'h78, 0, "R11 rx emptied");
    check(cmd_valid == 1'b0, "R11 no cmd disabled", int'(cmd_valid), 0);
    bus_wr(8'h6C, 32'd1, o);
    expect_reg(8'h6C, 1, "R8 enable readback");
  endtask

  initial begin
    logic o;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_disabled_ignore();
    bus_wr(8'h6C, 32'd1, o);
    t_order();
    t_tx_overflow();
    t_reservation();
    t_thresholds();
    t_unmapped();
    t_disable_flush();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule